// File: doc/BRIEF.md
# Sync-Framed Checksum Signature Generator

This block compresses four serial test-data lines into a 16-bit signature for a built-in self test. A known stimulus is applied to the lines and the signature is compared against a precomputed value. On every clock without a sync, the signature register shifts left by one bit. Its top bit feeds back into a fixed set of lower bits, and each data line is folded in at its own bit position.

A sync pulse marks the end of one measurement frame and the start of the next. The sync comes from an internal frame counter. On the clock edge that sees the sync, two things happen together. The signature built so far is copied into a read-only result register, and the signature register is reloaded with the non-zero seed 0x0002. A one-cycle valid strobe goes out alongside each new result. The frame counter that makes the sync, the test-pattern source and the bus read path all sit outside this block.

Top module: `sig_chk_top`

## Requirements
- R1: On a clock edge with sync_i low, the signature becomes the old signature shifted left by one (zero into bit 0). When the old bit 15 was 1, the result is then XORed with 0x002D, which flips bits 0, 2, 3 and 5.
- R2: On a clock edge with sync_i low, the data lines are XORed into the shifted signature at fixed positions: data_i[0] at bit 0, data_i[1] at bit 4, data_i[2] at bit 8 and data_i[3] at bit 12.
- R3: On a clock edge with sync_i high, the signature register is reloaded with 0x0002.
- R4: On a clock edge with sync_i high, result_o takes the signature value held just before that edge. data_i during that cycle affects neither result_o nor the next frame.
- R5: result_vld_o is 1 for exactly the cycle after each sync edge and 0 otherwise.
- R6: result_o holds its value on every clock edge with sync_i low.
- R7: While rst is high, result_o is 0 and result_vld_o is 0, and the signature is set to 0x0002. A frame that starts right after reset therefore behaves as if it had just been synced. rst takes priority over sync_i.
- R8: Two sync edges in consecutive cycles yield result_o = 0x0002 for the second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame boundary pulse from the internal frame counter |
| data_i | input | 4 | Serial data lines; bit 0 is lane a through bit 3 lane d |
| result_o | output | 16 | Read-only signature result of the last completed frame |
| result_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The signature register itself cannot be seen from the ports, so two of its behaviours are the hardest to observe. One is the feedback path, which only acts once a 1 has travelled up to bit 15. The other is the rule that data presented during the sync cycle is thrown away.

The stimulus reaches the feedback path with all-zero frames of 14, 15 and 16 clocks. The seed bit climbs to bit 15 and is then folded back, and each frame length has a hand-worked expected result. Every sync cycle drives all four data lines high. Each following frame is checked against a value computed from the clean seed, so any leak of that data into the next frame shows up as a mismatch.

// File: rtl/sig_chk_pkg.sv
package sig_chk_pkg;
  localparam int unsigned SIG_W_DEF   = 16;
  localparam int unsigned LANES_DEF   = 4;
  localparam logic [15:0] SEED_DEF    = 16'h0002;
  localparam logic [15:0] FB_MASK_DEF = 16'h002D;
endpackage

// File: rtl/sig_chk_step.sv
module sig_chk_step #(
  parameter int unsigned SIG_W   = 16,
  parameter int unsigned LANES   = 4,
  parameter logic [SIG_W-1:0] FB_MASK = 16'h002D
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic [LANES-1:0] lane_i,
  output logic [SIG_W-1:0] nxt_o
);
  localparam int unsigned STRIDE = SIG_W / LANES;

  logic [SIG_W-1:0] inject;
  logic [SIG_W-1:0] shifted;
  logic [SIG_W-1:0] feedback;

  for (genvar i = 0; i < SIG_W; i++) begin : g_inj
    if ((i % STRIDE) == 0) begin : g_tap
      assign inject[i] = lane_i[i / STRIDE];
    end else begin : g_none
      assign inject[i] = 1'b0;
    end
  end

  assign shifted  = {sig_i[SIG_W-2:0], 1'b0};
  assign feedback = sig_i[SIG_W-1] ? FB_MASK : '0;
  assign nxt_o    = shifted ^ feedback ^ inject;
endmodule

// File: rtl/sig_chk_core.sv
module sig_chk_core #(
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] SEED = 16'h0002
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [SIG_W-1:0] nxt_i,
  output logic [SIG_W-1:0] sig_o
);
  always_ff @(posedge clk) begin
    if (rst || sync_i) sig_o <= SEED;
    else               sig_o <= nxt_i;
  end

  a_r3_reseed: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> sig_o == SEED);
endmodule

// File: rtl/sig_chk_capture.sv
module sig_chk_capture #(
  parameter int unsigned SIG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [SIG_W-1:0] result_o,
  output logic             vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= sync_i;
      if (sync_i) result_o <= sig_i;
    end
  end

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> result_o == $past(sig_i));
  a_r5_vld_set: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> vld_o);
  a_r5_vld_clr: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> !vld_o);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> $stable(result_o));
endmodule

// File: rtl/sig_chk_top.sv
module sig_chk_top
  import sig_chk_pkg::*;
#(
  parameter int unsigned SIG_W   = SIG_W_DEF,
  parameter int unsigned LANES   = LANES_DEF,
  parameter logic [SIG_W-1:0] SEED    = SEED_DEF,
  parameter logic [SIG_W-1:0] FB_MASK = FB_MASK_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [LANES-1:0] data_i,
  output logic [SIG_W-1:0] result_o,
  output logic             result_vld_o
);
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] sig_nxt;

  sig_chk_step #(.SIG_W(SIG_W), .LANES(LANES), .FB_MASK(FB_MASK)) u_step (
    .sig_i (sig),
    .lane_i(data_i),
    .nxt_o (sig_nxt)
  );

  sig_chk_core #(.SIG_W(SIG_W), .SEED(SEED)) u_core (
    .clk   (clk),
    .rst   (rst),
    .sync_i(sync_i),
    .nxt_i (sig_nxt),
    .sig_o (sig)
  );

  sig_chk_capture #(.SIG_W(SIG_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (sync_i),
    .sig_i   (sig),
    .result_o(result_o),
    .vld_o   (result_vld_o)
  );

  a_r1_plain_shift: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && data_i == '0 && !sig[SIG_W-1])
      |=> sig == {$past(sig[SIG_W-2:0]), 1'b0});
  a_r2_lane_a: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && data_i == LANES'(1) && !sig[SIG_W-1])
      |=> (sig[0] && sig[SIG_W-1:1] == $past(sig[SIG_W-2:0])));
endmodule

// File: tb/sig_chk_top_bench.sv
module sig_chk_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0;
  logic [3:0]  data_i = 4'h0;
  logic [15:0] result_o;
  logic        result_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] model = 16'h0002;
  logic [15:0] last_res = 16'h0000;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  sig_chk_top u_sig_chk_top (
    .clk(clk), .rst(rst), .sync_i(sync_i), .data_i(data_i),
    .result_o(result_o), .result_vld_o(result_vld_o)
  );

  // {data(4), fold cycles(8), expected result(16)}
  localparam logic [27:0] VEC [0:8] = '{
    28'h0_03_0010,  // R1 plain shift
    28'h0_0E_8000,  // R1 seed reaches bit 15
    28'h0_0F_002D,  // R1 feedback taps
    28'h0_10_005A,  // R1 shift after feedback
    28'h1_01_0005,  // R2 lane a -> bit 0
    28'h2_01_0014,  // R2 lane b -> bit 4
    28'h8_01_1004,  // R2 lane d -> bit 12
    28'hF_01_1115,  // R2 all lanes
    28'h0_00_0002   // R8 back-to-back sync
  };

  function automatic logic [15:0] ref_nxt(input logic [15:0] s, input logic [3:0] d);
    logic [15:0] t;
    t = {s[14:0], 1'b0};
    if (s[15]) t = t ^ 16'h002D;
    t[0]  = t[0]  ^ d[0];
    t[4]  = t[4]  ^ d[1];
    t[8]  = t[8]  ^ d[2];
    t[12] = t[12] ^ d[3];
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] d, input int n, input bit rnd,
                       input bit fixed, input logic [15:0] exp_fixed, input string req);
    logic [15:0] exp;
    for (int i = 0; i < n; i++) begin
      data_i = rnd ? lfsr[3:0] : d;
      sync_i = 1'b0;
      model  = ref_nxt(model, data_i);
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(posedge clk); @(negedge clk);
      if (i == 0) begin
        chk(result_vld_o == 1'b0, "R5 strobe low", {15'd0, result_vld_o}, 16'h0);
        chk(result_o == last_res, "R6 hold", result_o, last_res);
      end
    end
    sync_i = 1'b1;
    data_i = 4'hF;  // R4: must be discarded
    @(posedge clk); @(negedge clk);
    sync_i = 1'b0;
    exp = fixed ? exp_fixed : model;
    chk(result_o == exp, req, result_o, exp);
    chk(result_vld_o == 1'b1, "R5 strobe high", {15'd0, result_vld_o}, 16'h1);
    last_res = exp;
    model = 16'h0002;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result_o == 16'h0, "R7 reset result", result_o, 16'h0);
    chk(result_vld_o == 1'b0, "R7 reset strobe", {15'd0, result_vld_o}, 16'h0);
    rst = 1'b0;

    // R7: first frame after reset starts from 0x0002 without a sync
    frame(4'h0, 5, 1'b0, 1'b1, 16'h0040, "R7 seed after reset");

    for (int k = 0; k < 9; k++) begin
      frame(VEC[k][27:24], int'(VEC[k][23:16]), 1'b0, 1'b1, VEC[k][15:0], "R1/R2 table");
    end

    // R3/R4: frames after the noisy sync cycles start from the clean seed
    for (int k = 0; k < 6; k++) begin
      frame(4'h0, 3 + 7 * k, 1'b1, 1'b0, 16'h0, "R3 R4 random frame");
    end

    // R8: two syncs in a row
    frame(4'h0, 0, 1'b0, 1'b1, 16'h0002, "R8 back-to-back");

    // R7: reset mid-frame with sync held, reset wins
    data_i = 4'h5; @(posedge clk); @(negedge clk);
    rst = 1'b1; sync_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(result_o == 16'h0, "R7 reset over sync", result_o, 16'h0);
    chk(result_vld_o == 1'b0, "R7 reset over sync strobe", {15'd0, result_vld_o}, 16'h0);
    rst = 1'b0; sync_i = 1'b0;
    last_res = 16'h0;
    model = 16'h0002;
    frame(4'h0, 2, 1'b0, 1'b1, 16'h0008, "R7 seed after mid reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule